// File: doc/BRIEF.md
# Job-Slot Interrupt and State Controller

This block gathers completion and failure events from sixteen job slots into a 32-bit raw interrupt word. The low half holds one "done" bit per slot and the high half holds one "failed" bit per slot. A software-programmed enable mask gates that word onto a single interrupt line. Software acknowledges events by writing ones to a clear register.

The same clear write also takes a fresh snapshot of each touched slot's execution state into a job-state register. That register has two bits per slot: one for "a job is running" and one for "another job is waiting behind it". Only the slots named by the clear are resampled, so an interrupt handler sees current state for the slots it services. Every other slot keeps its earlier snapshot.

Register offsets (byte addresses, 12-bit): 0x000 raw status, 0x004 clear, 0x008 enable mask, 0x00C masked status, 0x010 job state. Offsets from 0x800 upward belong to the per-slot register space and are not served here.

Top module: `job_slot_ctrl`

## Requirements
- R1: A one-cycle pulse on done_i[n] sets raw status bit n at the next clock edge.
- R2: A one-cycle pulse on fail_i[n] sets raw status bit 16+n at the next clock edge.
- R3: Writing the clear register (0x004) clears every raw status bit written as 1. Bits written as 0 are left unchanged. Reading 0x004 returns zero.
- R4: When an event pulse and a clear of the same raw bit fall in the same cycle, the bit ends up set.
- R5: The enable mask (0x008) is read/write. Reading the masked status (0x00C) returns raw status AND mask.
- R6: irq_o is high exactly when raw status AND mask is nonzero, and it updates in the cycle after the register change.
- R7: A clear write resamples slot n whenever bit n or bit 16+n of the written value is 1. Job-state bit n takes active_i[n] and bit 16+n takes queued_i[n] at that edge.
- R8: On a clear write, the job-state bits of slots not named in the value keep their previous values. Without a clear write, the job state does not change.
- R9: Writes to raw status (0x000), masked status (0x00C) and job state (0x010) have no effect.
- R10: After reset, raw status, mask, job state and rdata_o are zero, and irq_o is low.
- R11: Read data appears on rdata_o on the clock edge that samples re_i. It is zero after any cycle without a read, and reads of unmapped offsets return zero.
- R12: Accesses at offsets 0x800 and above are ignored. Writes there change nothing, and reads return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe |
| addr_i | input | 12 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| done_i | input | 16 | Per-slot job-done pulses |
| fail_i | input | 16 | Per-slot job-failed pulses |
| active_i | input | 16 | Per-slot running-job status |
| queued_i | input | 16 | Per-slot queued-job status |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a clear write whose value names a slot only through its failed bit (16+n). The resample must still happen for that slot while the neighbouring snapshots stay frozen, and an event on the same bit in the same cycle must still win. Random stimulus makes events sparse and the active/queued inputs dense, so most clears change visible state. Directed steps then place a done pulse and a clear of the same bit in one cycle, and issue a clear that names slots through their high-half bits alone.

// File: rtl/jsc_pkg.sv
package jsc_pkg;
  localparam int NUM_SLOTS = 16;
  localparam int ADDR_W    = 12;

  localparam logic [ADDR_W-1:0] OFS_RAW   = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_PEND  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_JOBST = 12'h010;
  localparam logic [ADDR_W-1:0] SLOT_BASE = 12'h800;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_RAW, SEL_CLR, SEL_MASK, SEL_PEND, SEL_JOBST
  } reg_sel_e;
endpackage

// File: rtl/jsc_regif.sv
module jsc_regif
  import jsc_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int W  = 2 * NUM_SLOTS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  raw_i,
  input  logic [W-1:0]  mask_i,
  input  logic [W-1:0]  jobst_i,
  output logic          clr_we_o,
  output logic          mask_we_o,
  output logic [W-1:0]  rdata_o
);
  reg_sel_e sel;

  always_comb begin
    sel = SEL_NONE;
    if (addr_i < SLOT_BASE) begin
      unique case (addr_i)
        OFS_RAW:   sel = SEL_RAW;
        OFS_CLR:   sel = SEL_CLR;
        OFS_MASK:  sel = SEL_MASK;
        OFS_PEND:  sel = SEL_PEND;
        OFS_JOBST: sel = SEL_JOBST;
        default:   sel = SEL_NONE;
      endcase
    end
  end

  assign clr_we_o  = we_i && (sel == SEL_CLR);
  assign mask_we_o = we_i && (sel == SEL_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
    end else if (!re_i) begin
      rdata_o <= '0;
    end else begin
      unique case (sel)
        SEL_RAW:   rdata_o <= raw_i;
        SEL_MASK:  rdata_o <= mask_i;
        SEL_PEND:  rdata_o <= raw_i & mask_i;
        SEL_JOBST: rdata_o <= jobst_i;
        default:   rdata_o <= '0;
      endcase
    end
  end

  p_idle_rdata_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> (rdata_o == '0));
  p_high_ofs_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i >= SLOT_BASE) |-> (!clr_we_o && !mask_we_o));
  p_high_read_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i >= SLOT_BASE) |=> (rdata_o == '0));
endmodule

// File: rtl/jsc_irq_core.sv
module jsc_irq_core
  import jsc_pkg::*;
#(
  parameter int NS = NUM_SLOTS,
  localparam int W = 2 * NS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NS-1:0] done_i,
  input  logic [NS-1:0] fail_i,
  input  logic          clr_we_i,
  input  logic          mask_we_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  raw_o,
  output logic [W-1:0]  mask_o,
  output logic          irq_o
);
  logic [W-1:0] evt;
  logic [W-1:0] clr_bits;

  assign evt      = {fail_i, done_i};
  assign clr_bits = clr_we_i ? wdata_i : '0;

  // event set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_o <= '0;
    else         raw_o <= (raw_o & ~clr_bits) | evt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_o <= '0;
    else if (mask_we_i) mask_o <= wdata_i;
  end

  assign irq_o = |(raw_o & mask_o);

  p_done_sets_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i != '0) |=> ((raw_o[NS-1:0] & $past(done_i)) == $past(done_i)));
  p_fail_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_i != '0) |=> ((raw_o[W-1:NS] & $past(fail_i)) == $past(fail_i)));
  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && evt == '0) |=> ((raw_o & $past(wdata_i)) == '0));
  p_event_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && (evt & wdata_i) != '0) |=> ((raw_o & $past(evt & wdata_i)) == $past(evt & wdata_i)));
  p_quiet_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_we_i && evt == '0) |=> $stable(raw_o));
endmodule

// File: rtl/jsc_state_snap.sv
module jsc_state_snap
  import jsc_pkg::*;
#(
  parameter int NS = NUM_SLOTS,
  localparam int W = 2 * NS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_we_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [NS-1:0] active_i,
  input  logic [NS-1:0] queued_i,
  output logic [W-1:0]  jobst_o
);
  logic [NS-1:0] hit;
  assign hit = wdata_i[NS-1:0] | wdata_i[W-1:NS];

  for (genvar n = 0; n < NS; n++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        jobst_o[n]    <= 1'b0;
        jobst_o[NS+n] <= 1'b0;
      end else if (clr_we_i && hit[n]) begin
        jobst_o[n]    <= active_i[n];
        jobst_o[NS+n] <= queued_i[n];
      end
    end
  end

  p_resample_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((jobst_o & $past({hit, hit})) == $past({queued_i, active_i} & {hit, hit})));
  p_keep_other_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((jobst_o & ~$past({hit, hit})) == ($past(jobst_o) & ~$past({hit, hit}))));
  p_no_clear_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_we_i |=> $stable(jobst_o));
endmodule

// File: rtl/job_slot_ctrl.sv
module job_slot_ctrl
  import jsc_pkg::*;
#(
  parameter int NS = NUM_SLOTS,
  parameter int AW = ADDR_W,
  localparam int W = 2 * NS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  input  logic [NS-1:0] done_i,
  input  logic [NS-1:0] fail_i,
  input  logic [NS-1:0] active_i,
  input  logic [NS-1:0] queued_i,
  output logic          irq_o
);
  logic         clr_we, mask_we;
  logic [W-1:0] raw, mask, jobst;

  jsc_regif #(.AW(AW), .W(W)) u_regif (
    .clk_i, .rst_ni, .we_i, .re_i, .addr_i,
    .raw_i(raw), .mask_i(mask), .jobst_i(jobst),
    .clr_we_o(clr_we), .mask_we_o(mask_we), .rdata_o
  );

  jsc_irq_core #(.NS(NS)) u_irq (
    .clk_i, .rst_ni, .done_i, .fail_i,
    .clr_we_i(clr_we), .mask_we_i(mask_we), .wdata_i,
    .raw_o(raw), .mask_o(mask), .irq_o
  );

  jsc_state_snap #(.NS(NS)) u_snap (
    .clk_i, .rst_ni, .clr_we_i(clr_we), .wdata_i,
    .active_i, .queued_i, .jobst_o(jobst)
  );

  p_irq_needs_raw_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (raw != '0 && mask != '0));
endmodule

// File: tb/job_slot_ctrl_tb_top.sv
module job_slot_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;
  localparam int W  = 32;

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic          we_i = 1'b0, re_i = 1'b0;
  logic [11:0]   addr_i = '0;
  logic [W-1:0]  wdata_i = '0, rdata_o;
  logic [NS-1:0] done_i = '0, fail_i = '0, active_i = '0, queued_i = '0;
  logic          irq_o;

  int checks = 0, failures = 0;
  bit finished = 1'b0;
  logic [W-1:0] m_raw = '0, m_mask = '0, m_st = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  job_slot_ctrl dut_i (.*);

  function automatic logic [W-1:0] rd_model(logic [11:0] a);
    case (a)
      12'h000: return m_raw;
      12'h008: return m_mask;
      12'h00C: return m_raw & m_mask;
      12'h010: return m_st;
      default: return '0;
    endcase
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive, clock, update model, check
  task automatic step(string req, bit we, bit re, logic [11:0] a, logic [W-1:0] wd,
                      logic [NS-1:0] dn, logic [NS-1:0] fl, logic [NS-1:0] ac, logic [NS-1:0] qu);
    logic [W-1:0] exp_rd, clr;
    logic [NS-1:0] hit;
    we_i = we; re_i = re; addr_i = a; wdata_i = wd;
    done_i = dn; fail_i = fl; active_i = ac; queued_i = qu;
    exp_rd = re ? rd_model(a) : '0;
    clr = (we && a == 12'h004) ? wd : '0;
    hit = clr[NS-1:0] | clr[W-1:NS];
    @(posedge clk_i); #1;
    m_raw = (m_raw & ~clr) | {fl, dn};
    if (we && a == 12'h008) m_mask = wd;
    m_st = (m_st & ~{hit, hit}) | ({qu, ac} & {hit, hit});
    check({req, " rdata R11"}, rdata_o, exp_rd);
    check({req, " irq R6"}, {31'd0, irq_o}, {31'd0, |(m_raw & m_mask)});
    we_i = 0; re_i = 0; done_i = '0; fail_i = '0;
  endtask

  task automatic rd(string req, logic [11:0] a);
    step(req, 0, 1, a, '0, '0, '0, active_i, queued_i);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [11:0] addrs [8];
    addrs = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010, 12'h014, 12'h800, 12'h80C};
    void'($urandom(32'h5EED_0042));
    #(CLK_PERIOD * 3 + 1);
    check("R10 rdata", rdata_o, '0);
    check("R10 irq", {31'd0, irq_o}, '0);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    rd("R10 raw", 12'h000); rd("R10 mask", 12'h008); rd("R10 jobst", 12'h010);

    // R1, R2 events
    step("R1 done", 0, 0, '0, '0, 16'h0005, '0, '0, '0);
    step("R2 fail", 0, 0, '0, '0, '0, 16'h8000, '0, '0);
    rd("R1 R2 raw", 12'h000);
    // R5 mask and masked status
    step("R5 mask wr", 1, 0, 12'h008, 32'h8000_0001, '0, '0, '0, '0);
    rd("R5 mask", 12'h008); rd("R5 pend", 12'h00C);
    // R12 high offset alias of mask ignored
    step("R12 wr", 1, 0, 12'h808, 32'hFFFF_FFFF, '0, '0, '0, '0);
    rd("R12 mask", 12'h008); rd("R12 rd", 12'h808);
    // R9 writes to read-only regs ignored
    step("R9 wr raw", 1, 0, 12'h000, 32'hFFFF_FFFF, '0, '0, '0, '0);
    step("R9 wr pend", 1, 0, 12'h00C, 32'h0, '0, '0, '0, '0);
    step("R9 wr st", 1, 0, 12'h010, 32'hFFFF_FFFF, '0, '0, '0, '0);
    rd("R9 raw", 12'h000); rd("R9 st", 12'h010);
    // R4 event and clear on same bit
    step("R4 race", 1, 0, 12'h004, 32'h0000_0001, 16'h0001, '0, 16'hFFFF, 16'hFFFF);
    rd("R4 raw", 12'h000);
    // R3 clear, R7 resample via high bit only, R8 others kept
    step("R3 R7 clr", 1, 0, 12'h004, 32'h8000_0004, '0, '0, 16'hFFFF, 16'h0000);
    rd("R3 raw", 12'h000); rd("R7 R8 st", 12'h010);
    step("R7 clr hi", 1, 0, 12'h004, 32'h0002_0000, '0, '0, 16'h0000, 16'h0002);
    rd("R7 R8 st2", 12'h010); rd("R3 clr rd", 12'h004);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [11:0] a;
      a = addrs[$urandom_range(0, 7)];
      step("RND R1 R2 R3 R5 R7 R8 R9 R12", $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1, a,
           $urandom, 16'($urandom & $urandom & $urandom), 16'($urandom & $urandom & $urandom),
           16'($urandom), 16'($urandom));
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule